// File: doc/BRIEF.md
# SD Command Issue and Response Unit

This unit takes one card command at a time from register writes and runs it on the serial command line. Software first writes a 32-bit argument and then a 16-bit command word. Writing the command word starts the command. The unit builds a 48-bit host frame and sends it one bit per card-clock tick. It then waits for the card's reply and captures it into a 128-bit response store. Depending on the command word, it also checks the reply's CRC7 and the echoed command index.

Two inhibit flags show when the command line is busy and when the data lines are busy. A small write-1-to-clear status register reports completion, timeout and the two check errors. Some replies are followed by busy signalling on DAT0, where the card holds DAT0 low. For those, completion is held back until the card releases DAT0. A data engine outside this unit owns the data lines. It reports the end of a data transfer with a single pulse.

Top module: `sd_cmd_unit`

## Requirements
- R1: After reset, both inhibit flags and all status bits are 0, `cmd_oe` is 0, `cmd_out` is 1 and `rsp_out` is 0.
- R2: An accepted command is sent as 48 bits, most significant first, one bit per `card_tick`: 0, 1, index[5:0], argument[31:0], CRC7 of the first 40 bits (polynomial x^7+x^3+1, initial value 0), then 1. `cmd_oe` is high for exactly these 48 ticks.
- R3: `inhibit_cmd` rises in the cycle after an accepted command write. It falls when the command phase ends: after the last sent bit when no reply is expected, after the last reply bit, or on timeout.
- R4: A command write is ignored while a command is in progress. A command write is also ignored if any reserved bit (15, 14, 7, 6 or 2) is 1.
- R5: Command word fields: index in bits [13:8], data-present in bit 5, index-check in bit 4, CRC-check in bit 3, reply type in bits [1:0]. `inhibit_dat` rises with the write when data-present is set or the reply type is 11. A `dat_xfer_done` pulse clears `inhibit_dat`.
- R6: Reply type 10 or 11 is a 48-bit reply. After it, `rsp_out[31:0]` holds the 32-bit content and `rsp_out[127:32]` is 0.
- R7: Reply type 01 is a 136-bit reply. After it, `rsp_out` holds reply bits [127:8] in `rsp_out[119:0]`, and `rsp_out[127:120]` is 0.
- R8: With CRC-check set, a CRC7 mismatch or an end bit of 0 sets status bit 2. With index-check set on a 48-bit reply, an echoed index that differs from the sent index sets status bit 3. With the check bits cleared, neither status bit is set.
- R9: If no start bit arrives within 64 ticks after the frame, status bit 1 is set, both inhibit flags clear and status bit 0 stays 0.
- R10: For reply type 11, status bit 0 and the clearing of `inhibit_dat` wait until DAT0 is seen high after the reply.
- R11: Status bit 0 is command complete. Writing 1 to a status bit clears it, and a set in the same cycle takes priority over the clear. `err_sum` is the OR of status bits 3 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_we | input | 1 | Command word write strobe; starts a command |
| cmd_wdata | input | 16 | Command word write data |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 4 | Write-1-to-clear mask for the status bits |
| dat_xfer_done | input | 1 | Pulse from the data engine ending a transfer |
| card_tick | input | 1 | One-cycle card-clock enable |
| cmd_in | input | 1 | Command line level from the card |
| dat0_in | input | 1 | DAT0 line level |
| cmd_out | output | 1 | Command line level to the card |
| cmd_oe | output | 1 | Command line drive enable |
| inhibit_cmd | output | 1 | Command line in use |
| inhibit_dat | output | 1 | Data lines in use |
| int_status | output | 4 | Status: [0] complete, [1] timeout, [2] CRC error, [3] index error |
| err_sum | output | 1 | Any error status bit set |
| rsp_out | output | 128 | Captured response |

## Verification
The bound checker checks several relations on every cycle:
- `cmd_oe` implies `inhibit_cmd`.
- A rise of `inhibit_cmd` always follows a command write.
- `inhibit_dat` never rises on its own.
- A timeout always leaves both flags low.
- `inhibit_dat` falls only after DAT0 high, a done pulse or a timeout.

Other behaviour is visible only in the bench scenarios, where a card model answers each frame: the exact bit order and CRC of the sent frame, how long and short replies are placed in the response store, which corrupted replies raise which error bit, and how long completion is held during busy.

// File: rtl/sd_cmd_unit.sv
module sd_cmd_unit #(
  parameter int TO_TICKS = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arg_we,
  input  logic [31:0]  arg_wdata,
  input  logic         cmd_we,
  input  logic [15:0]  cmd_wdata,
  input  logic         sts_we,
  input  logic [3:0]   sts_wdata,
  input  logic         dat_xfer_done,
  input  logic         card_tick,
  input  logic         cmd_in,
  input  logic         dat0_in,
  output logic         cmd_out,
  output logic         cmd_oe,
  output logic         inhibit_cmd,
  output logic         inhibit_dat,
  output logic [3:0]   int_status,
  output logic         err_sum,
  output logic [127:0] rsp_out
);
  localparam int TOW = $clog2(TO_TICKS) + 1;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RECV, S_BUSY} st_t;

  st_t          st;
  logic [31:0]  arg_q;
  logic [5:0]   idx_q;
  logic [1:0]   rtyp_q;
  logic         chk_crc_q, chk_idx_q;
  logic [47:0]  tx_sr;
  logic [7:0]   cnt;
  logic [TOW-1:0] to_cnt;
  logic [126:0] rx_sr;
  logic [127:0] rx_nxt;
  logic         inh_c, inh_d;
  logic [3:0]   sts, sts_set;
  logic [127:0] rsp;

  function automatic logic [6:0] crc7(input logic [119:0] d, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 119; i >= 0; i--) begin
      if (i < n) begin
        fb = d[i] ^ c[6];
        c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
    end
    return c;
  endfunction

  wire [39:0] head    = {2'b01, cmd_wdata[13:8], arg_q};
  wire        accept  = cmd_we && (st == S_IDLE) && ((cmd_wdata & 16'hC0C4) == 16'h0000);
  wire        is_long = (rtyp_q == 2'b01);
  wire [7:0]  rlen_m1 = is_long ? 8'd135 : 8'd47;
  wire        last    = (st == S_RECV) && card_tick && (cnt == rlen_m1);
  assign rx_nxt = {rx_sr, cmd_in};
  wire        crc_ok  = rx_nxt[0] && (is_long ? (crc7(rx_nxt[127:8], 120) == rx_nxt[7:1])
                                              : (crc7({80'b0, rx_nxt[47:8]}, 40) == rx_nxt[7:1]));

  always_comb begin
    sts_set = 4'h0;
    if (st == S_SEND && card_tick && cnt == 8'd47 && rtyp_q == 2'b00) sts_set[0] = 1'b1;
    if (st == S_WAIT && card_tick && cmd_in && to_cnt == TOW'(TO_TICKS - 1)) sts_set[1] = 1'b1;
    if (last) begin
      sts_set[0] = (rtyp_q != 2'b11);
      sts_set[2] = chk_crc_q && !crc_ok;
      sts_set[3] = chk_idx_q && !is_long && (rx_nxt[45:40] != idx_q);
    end
    if (st == S_BUSY && dat0_in) sts_set[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; arg_q <= '0; idx_q <= '0; rtyp_q <= '0;
      chk_crc_q <= 1'b0; chk_idx_q <= 1'b0; tx_sr <= '0; cnt <= '0;
      to_cnt <= '0; rx_sr <= '0; inh_c <= 1'b0; inh_d <= 1'b0;
      sts <= '0; rsp <= '0;
    end else begin
      sts <= (sts & ~(sts_we ? sts_wdata : 4'h0)) | sts_set;
      if (arg_we) arg_q <= arg_wdata;
      if (dat_xfer_done) inh_d <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          idx_q     <= cmd_wdata[13:8];
          rtyp_q    <= cmd_wdata[1:0];
          chk_idx_q <= cmd_wdata[4];
          chk_crc_q <= cmd_wdata[3];
          tx_sr     <= {head, crc7({80'b0, head}, 40), 1'b1};
          cnt       <= '0;
          inh_c     <= 1'b1;
          if (cmd_wdata[5] || cmd_wdata[1:0] == 2'b11) inh_d <= 1'b1;
          st        <= S_SEND;
        end
        S_SEND: if (card_tick) begin
          tx_sr <= {tx_sr[46:0], 1'b0};
          cnt   <= cnt + 8'd1;
          if (cnt == 8'd47) begin
            if (rtyp_q == 2'b00) begin
              st    <= S_IDLE;
              inh_c <= 1'b0;
            end else begin
              st     <= S_WAIT;
              to_cnt <= '0;
            end
          end
        end
        S_WAIT: if (card_tick) begin
          if (!cmd_in) begin
            st    <= S_RECV;
            cnt   <= 8'd1;
            rx_sr <= rx_nxt[126:0];
          end else if (to_cnt == TOW'(TO_TICKS - 1)) begin
            st    <= S_IDLE;
            inh_c <= 1'b0;
            inh_d <= 1'b0;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        S_RECV: if (card_tick) begin
          rx_sr <= rx_nxt[126:0];
          cnt   <= cnt + 8'd1;
          if (last) begin
            inh_c <= 1'b0;
            rsp   <= is_long ? {8'b0, rx_nxt[127:8]} : {96'b0, rx_nxt[39:8]};
            st    <= (rtyp_q == 2'b11) ? S_BUSY : S_IDLE;
          end
        end
        S_BUSY: if (dat0_in) begin
          inh_d <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_oe      = (st == S_SEND);
  assign cmd_out     = (st == S_SEND) ? tx_sr[47] : 1'b1;
  assign inhibit_cmd = inh_c;
  assign inhibit_dat = inh_d;
  assign int_status  = sts;
  assign err_sum     = |sts[3:1];
  assign rsp_out     = rsp;
endmodule

module sd_cmd_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic       dat_xfer_done,
  input logic       dat0_in,
  input logic       cmd_oe,
  input logic       inhibit_cmd,
  input logic       inhibit_dat,
  input logic [3:0] int_status
);
  AST_OE_UNDER_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> inhibit_cmd); // R2
  AST_INHIBIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit_cmd) |-> $past(cmd_we)); // R3
  AST_COMPLETE_FREES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[0]) |-> !inhibit_cmd); // R3
  AST_DAT_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit_dat) |-> $rose(inhibit_cmd)); // R5
  AST_TIMEOUT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[1]) |-> (!inhibit_cmd && !inhibit_dat)); // R9
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inhibit_dat) |-> ($past(dat0_in) || $past(dat_xfer_done) || int_status[1])); // R10
endmodule

bind sd_cmd_unit sd_cmd_unit_chk u_chk (.*);

// File: tb/sd_cmd_unit_bench.sv
module sd_cmd_unit_bench;
  localparam int CLK_P = 10;
  localparam int TO    = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arg_we = 0, cmd_we = 0, sts_we = 0, dat_xfer_done = 0, card_tick = 0;
  logic cmd_in = 1, dat0_in = 1;
  logic [31:0] arg_wdata = '0;
  logic [15:0] cmd_wdata = '0;
  logic [3:0]  sts_wdata = '0;
  logic cmd_out, cmd_oe, inhibit_cmd, inhibit_dat, err_sum;
  logic [3:0] int_status;
  logic [127:0] rsp_out;

  sd_cmd_unit u_sd_cmd_unit (.*);

  always #(CLK_P/2) clk = ~clk;

  int nvec = 0, nerr = 0;
  bit cmp_on = 0;
  logic exp_inh_c = 0, exp_inh_d = 0, exp_oe = 0;
  logic [3:0] exp_sts = '0;

  task automatic chk(input string rq, input logic [135:0] act, input logic [135:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R3 inhibit_cmd", 136'(inhibit_cmd), 136'(exp_inh_c));
    chk("R5 inhibit_dat", 136'(inhibit_dat), 136'(exp_inh_d));
    chk("R11 status",     136'(int_status), 136'(exp_sts));
    chk("R11 err_sum",    136'(err_sum), 136'(|exp_sts[3:1]));
    chk("R2 cmd_oe",      136'(cmd_oe), 136'(exp_oe));
  end

  function automatic logic [6:0] bcrc(input logic [119:0] d, input int n);
    logic [6:0] r;
    logic b;
    r = '0;
    for (int k = n - 1; k >= 0; k--) begin
      b = d[k] ^ r[6];
      r = {r[5:0], b};
      r[3] = r[3] ^ b;
    end
    return r;
  endfunction

  function automatic logic [15:0] mkcw(input logic [5:0] idx, input bit dp, input bit ci,
                                       input bit cc, input logic [1:0] rt);
    return {2'b00, idx, 2'b00, dp, ci, cc, 1'b0, rt};
  endfunction

  function automatic logic [135:0] mk48(input logic [5:0] echo, input logic [31:0] c, input bit bad);
    logic [39:0] h;
    h = {2'b00, echo, c};
    return {88'b0, h, bcrc({80'b0, h}, 40) ^ (bad ? 7'h01 : 7'h00), 1'b1};
  endfunction

  function automatic logic [135:0] mk136(input logic [119:0] f);
    return {2'b00, 6'h3f, f, bcrc(f, 120), 1'b1};
  endfunction

  task automatic tick(input logic b, output logic hb);
    repeat (2) @(negedge clk);
    @(negedge clk);
    hb = cmd_out; card_tick = 1; cmd_in = b;
    @(posedge clk);
    #1 card_tick = 0;
  endtask

  task automatic wr_arg(input logic [31:0] a);
    @(negedge clk); arg_we = 1; arg_wdata = a;
    @(posedge clk); #1 arg_we = 0;
  endtask

  task automatic wr_cmd(input logic [15:0] c);
    @(negedge clk); cmd_we = 1; cmd_wdata = c;
    @(posedge clk);
    #1 cmd_we = 0;
    if (!exp_inh_c && (c & 16'hC0C4) == 0) begin
      exp_inh_c = 1; exp_oe = 1;
      if (c[5] || c[1:0] == 2'b11) exp_inh_d = 1;
    end
  endtask

  task automatic clr(input logic [3:0] m);
    @(negedge clk); sts_we = 1; sts_wdata = m;
    @(posedge clk); #1 sts_we = 0;
    exp_sts = exp_sts & ~m;
  endtask

  task automatic run_cmd(input logic [15:0] cw, input logic [31:0] arg, input int gap,
                         input logic [135:0] rf, input int rlen, input logic [3:0] eerr,
                         input logic [127:0] er, input string rq, input int busy_clks,
                         input bit poke);
    logic [47:0] got;
    logic [39:0] h;
    logic hb;
    got = '0;
    wr_arg(arg);
    wr_cmd(cw);
    for (int i = 0; i < 48; i++) begin
      tick(1'b1, hb);
      got = {got[46:0], hb};
      if (poke && i == 10) wr_cmd(mkcw(6'd33, 0, 0, 0, 2'b00));
    end
    exp_oe = 0;
    h = {2'b01, cw[13:8], arg};
    chk(poke ? "R4 frame after ignored write" : "R2 frame", 136'(got), 136'({h, bcrc({80'b0, h}, 40), 1'b1}));
    if (cw[1:0] == 2'b00) begin
      exp_inh_c = 0; exp_sts[0] = 1;
      return;
    end
    if (cw[1:0] == 2'b11) dat0_in = 0;
    for (int i = 0; i < gap; i++) begin
      tick(1'b1, hb);
      if (i == TO - 1) begin
        exp_inh_c = 0; exp_inh_d = 0; exp_sts[1] = 1; dat0_in = 1;
        return;
      end
    end
    for (int i = rlen - 1; i >= 0; i--) tick(rf[i], hb);
    exp_inh_c = 0;
    exp_sts = exp_sts | eerr;
    if (cw[1:0] != 2'b11) exp_sts[0] = 1;
    @(negedge clk);
    chk(rq, 136'(rsp_out), 136'(er));
    if (cw[1:0] == 2'b11) begin
      repeat (busy_clks) @(negedge clk);
      dat0_in = 1;
      @(posedge clk);
      #1 exp_sts[0] = 1; exp_inh_d = 0;
    end
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [119:0] fld;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    chk("R1 rsp_out", 136'(rsp_out), 136'(0));
    chk("R1 cmd_out", 136'(cmd_out), 136'(1));
    chk("R1 status", 136'(int_status), 136'(0));

    // R2 R3: no-reply command
    run_cmd(mkcw(6'd0, 0, 0, 0, 2'b00), 32'h0, 0, '0, 0, 4'h0, '0, "R3", 0, 0);
    clr(4'h1);

    // R4: reserved bit set while idle is ignored
    wr_cmd(16'h0004 | mkcw(6'd3, 0, 0, 0, 2'b10));
    repeat (3) @(negedge clk);

    // R6: short reply with both checks
    run_cmd(mkcw(6'd17, 0, 1, 1, 2'b10), 32'h1234_5678, 5, mk48(6'd17, 32'hCAFE_0123, 0), 48,
            4'h0, {96'b0, 32'hCAFE_0123}, "R6 short reply", 0, 0);
    clr(4'h1);

    // R8: bad CRC and wrong echo, then partial clear (R11)
    run_cmd(mkcw(6'd9, 0, 1, 1, 2'b10), 32'hA5A5_0F0F, 2, mk48(6'd10, 32'h0000_BEEF, 1), 48,
            4'b1100, {96'b0, 32'h0000_BEEF}, "R8 errors", 0, 0);
    clr(4'b0100);
    clr(4'hF);

    // R8: checks off, same corruption raises nothing
    run_cmd(mkcw(6'd9, 0, 0, 0, 2'b10), 32'h0, 1, mk48(6'd11, 32'h7777_0001, 1), 48,
            4'h0, {96'b0, 32'h7777_0001}, "R8 checks off", 0, 0);
    clr(4'h1);

    // R7: long reply
    fld = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
    run_cmd(mkcw(6'd2, 0, 0, 1, 2'b01), 32'h0, 3, mk136(fld), 136,
            4'h0, {8'b0, fld}, "R7 long reply", 0, 0);
    clr(4'h1);

    // R9: no start bit
    run_cmd(mkcw(6'd8, 0, 0, 0, 2'b10), 32'h1AA, 100, '0, 48, 4'h0, '0, "R9", 0, 0);
    clr(4'h2);

    // R10: busy reply
    run_cmd(mkcw(6'd7, 0, 1, 1, 2'b11), 32'h0001_0000, 4, mk48(6'd7, 32'h0000_0900, 0), 48,
            4'h0, {96'b0, 32'h0000_0900}, "R10 busy reply", 20, 0);
    clr(4'h1);

    // R4: write during send is ignored
    run_cmd(mkcw(6'd13, 0, 1, 1, 2'b10), 32'hDEAD_0001, 2, mk48(6'd13, 32'h0000_0055, 0), 48,
            4'h0, {96'b0, 32'h0000_0055}, "R4 reply", 0, 1);
    clr(4'h1);

    // R5: data-present holds inhibit_dat until done pulse
    run_cmd(mkcw(6'd18, 1, 1, 1, 2'b10), 32'h0000_0200, 2, mk48(6'd18, 32'h0000_0900, 0), 48,
            4'h0, {96'b0, 32'h0000_0900}, "R5 reply", 0, 0);
    repeat (4) @(negedge clk);
    dat_xfer_done = 1;
    @(posedge clk);
    #1 dat_xfer_done = 0; exp_inh_d = 0;
    clr(4'h1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule